// File: doc/BRIEF.md
# Link Calibration Sequencer

This block steps one serial-link group through its two power-on calibrations. A single start pulse launches transmit impedance calibration. The block then waits a settle time and polls the engine's status at a fixed interval until the engine reports done or error, or until the poll budget runs out. The block keeps the pull-up and pull-down impedance results, rescaled to quarter-segment units, or it falls back to a nominal value when no valid result exists.

Receive DC offset calibration follows. Before it starts, the block marks every lane as usable and moves the receive clock onto the internal reference. It clears the receive done flag, starts the engine, and polls it in the same way as the transmit engine. After a successful finish it stops the engine, releases the clock handover together, waits, and marks every lane unusable again. The calibration engines and the PLL sit outside the block.

All waits are counted in clock cycles and set by parameters. Three sticky flags report a transmit error, a transmit timeout and a receive timeout. Each flag stays set until the next start.

Top module: `link_cal_seq`

## Requirements
- R1: After reset: busy_o, done_o, tx_cal_req_o, rx_done_clr_o, rx_start_o, all three clock-control outputs and all error flags are 0; every lane_invalid_o bit is 1; p_4r_o and n_4r_o are 0.
- R2: start_i in idle raises busy_o at the next edge and makes tx_cal_req_o high for exactly one cycle. start_i while busy_o is high is ignored: it produces no second request and does not disturb the sequence.
- R3: The first transmit status check takes place TX_SETTLE_CYC cycles after start is accepted. Further checks follow every TX_GAP_CYC+1 cycles. Polling ends at the first check that sees tx_cal_done_i or tx_cal_err_i. The phase-end outputs update at the edge that closes that check. tx_err_o copies tx_cal_err_i at that check.
- R4: If TX_POLLS checks pass with neither done nor error, tx_tmo_o is set and the sequence continues with default results.
- R5: At the end of the transmit phase, p_4r_o and n_4r_o become tx_p_res_i>>1 and tx_n_res_i>>1 when tx_cal_done_i was seen. Otherwise both become DEF_4R (100).
- R6: At that same edge all lane_invalid_o bits go to 0. One cycle later clk_ref_sel_o and clk_ovr_o go to 1. CLK_SETTLE_CYC cycles after that pll_pgood_o goes to 1. After PG_SETTLE_CYC more cycles rx_done_clr_o pulses for one cycle, and rx_start_o rises at the next edge.
- R7: The first receive check takes place RX_SETTLE_CYC cycles after rx_start_o rises. Further checks follow every RX_GAP_CYC+1 cycles. A done seen on the last allowed check (check number RX_POLLS) still counts as success.
- R8: On receive success, rx_start_o falls at the check edge. One cycle later clk_ref_sel_o, clk_ovr_o and pll_pgood_o fall together. OFF_SETTLE_CYC cycles later all lane_invalid_o bits return to 1, busy_o falls and done_o pulses for one cycle.
- R9: If RX_POLLS receive checks pass without done, rx_tmo_o is set, done_o pulses and busy_o falls at that edge. rx_start_o, the clock outputs and the cleared lane flags are left unchanged.
- R10: tx_err_o, tx_tmo_o and rx_tmo_o stay set after the sequence ends and are cleared when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch request, taken only when idle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| tx_cal_req_o | output | 1 | One-cycle transmit calibration request |
| tx_cal_done_i | input | 1 | Transmit engine finished (level) |
| tx_cal_err_i | input | 1 | Transmit engine error (level) |
| tx_p_res_i | input | RES_W | Pull-up result, eighth-segment units |
| tx_n_res_i | input | RES_W | Pull-down result, eighth-segment units |
| p_4r_o | output | RES_W | Pull-up result, quarter-segment units |
| n_4r_o | output | RES_W | Pull-down result, quarter-segment units |
| lane_invalid_o | output | LANES | Per-lane unusable flags |
| clk_ref_sel_o | output | 1 | Receive clock uses the internal reference |
| clk_ovr_o | output | 1 | Register override of the reference select |
| pll_pgood_o | output | 1 | Power-good to the receive clock PLL |
| rx_done_clr_o | output | 1 | One-cycle clear of the receive done flag |
| rx_start_o | output | 1 | Receive DC calibration run enable |
| rx_cal_done_i | input | 1 | Receive engine finished (level) |
| tx_err_o | output | 1 | Sticky transmit error |
| tx_tmo_o | output | 1 | Sticky transmit timeout |
| rx_tmo_o | output | 1 | Sticky receive timeout |

## Verification
The embedded properties rely on start_i being a synchronous signal. They also rely on the engine status inputs being held levels: the transmit pair changes only after a request, and the receive done rises only while rx_start_o is high and is dropped by the clear pulse. The bench engine models follow exactly this contract. Each model rearms on the request or on the rising run enable, and then raises its status after a programmed latency or never. The latencies are chosen so that each status edge lands several cycles away from any poll. This makes the expected poll count, and with it every expected output interval, unambiguous.

// File: rtl/link_cal_pkg.sv
// Shared types for the link calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package link_cal_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_TX_SETTLE,
        S_TX_CHECK,
        S_TX_GAP,
        S_CLK_ON,
        S_CLK_WAIT,
        S_PG_WAIT,
        S_RX_GO,
        S_RX_SETTLE,
        S_RX_CHECK,
        S_RX_GAP,
        S_CLK_OFF,
        S_OFF_WAIT
    } seq_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cal_delay_timer.sv
// Single down-counter used for every wait of the sequencer.
// Loading value V makes expired_o go high V cycles after the load edge.
// Assumes: load_i is a one-cycle strobe from the owning state machine.
module cal_delay_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    // Load on strobe, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= value_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cal_poll_counter.sv
// Counts status checks of the active poll loop.
// last_o is high while the check in progress is number limit_i.
// Assumes: limit_i >= 1 and is stable during a loop.
module cal_poll_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    // Clear when a poll loop begins, advance once per check.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clear_i)  cnt_q <= '0;
        else if (step_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/link_cal_seq.sv
// Sequencer for transmit impedance then receive DC calibration of one
// link group. It runs both poll loops, captures the impedance results,
// and handles lane-flag and clock handover around the receive phase.
// Assumes: engine status inputs are held levels; all *_CYC >= 1, POLLS >= 1.
module link_cal_seq #(
    parameter int unsigned TX_SETTLE_CYC  = 1_000_000,
    parameter int unsigned TX_GAP_CYC     = 500,
    parameter int unsigned TX_POLLS       = 200,
    parameter int unsigned CLK_SETTLE_CYC = 7_500,
    parameter int unsigned PG_SETTLE_CYC  = 250,
    parameter int unsigned RX_SETTLE_CYC  = 5_000_000,
    parameter int unsigned RX_GAP_CYC     = 500_000,
    parameter int unsigned RX_POLLS       = 200,
    parameter int unsigned OFF_SETTLE_CYC = 5_525,
    parameter int unsigned LANES          = 24,
    parameter int unsigned RES_W          = 9,
    parameter int unsigned DEF_4R         = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             tx_cal_req_o,
    input  logic             tx_cal_done_i,
    input  logic             tx_cal_err_i,
    input  logic [RES_W-1:0] tx_p_res_i,
    input  logic [RES_W-1:0] tx_n_res_i,
    output logic [RES_W-1:0] p_4r_o,
    output logic [RES_W-1:0] n_4r_o,
    output logic [LANES-1:0] lane_invalid_o,
    output logic             clk_ref_sel_o,
    output logic             clk_ovr_o,
    output logic             pll_pgood_o,
    output logic             rx_done_clr_o,
    output logic             rx_start_o,
    input  logic             rx_cal_done_i,
    output logic             tx_err_o,
    output logic             tx_tmo_o,
    output logic             rx_tmo_o
);
    import link_cal_pkg::*;

    localparam int unsigned MAX_D = max_u(max_u(max_u(TX_SETTLE_CYC, TX_GAP_CYC),
                                                max_u(CLK_SETTLE_CYC, PG_SETTLE_CYC)),
                                          max_u(max_u(RX_SETTLE_CYC, RX_GAP_CYC),
                                                OFF_SETTLE_CYC));
    localparam int unsigned TW = $clog2(MAX_D + 1);
    localparam int unsigned PW = $clog2(max_u(TX_POLLS, RX_POLLS) + 1);

    seq_state_e      state_q, nxt;
    logic            tmr_load, tmr_exp;
    logic [TW-1:0]   tmr_val;
    logic            pc_clear, pc_step, pc_last;
    logic [PW-1:0]   pc_limit;
    logic            tx_end;

    assign tx_end = tx_cal_done_i | tx_cal_err_i | pc_last;

    // Next-state selection.
    always_comb begin
        nxt = state_q;
        case (state_q)
            S_IDLE:      if (start_i) nxt = S_TX_SETTLE;
            S_TX_SETTLE: if (tmr_exp) nxt = S_TX_CHECK;
            S_TX_CHECK:  nxt = tx_end ? S_CLK_ON : S_TX_GAP;
            S_TX_GAP:    if (tmr_exp) nxt = S_TX_CHECK;
            S_CLK_ON:    nxt = S_CLK_WAIT;
            S_CLK_WAIT:  if (tmr_exp) nxt = S_PG_WAIT;
            S_PG_WAIT:   if (tmr_exp) nxt = S_RX_GO;
            S_RX_GO:     nxt = S_RX_SETTLE;
            S_RX_SETTLE: if (tmr_exp) nxt = S_RX_CHECK;
            S_RX_CHECK:  nxt = rx_cal_done_i ? S_CLK_OFF : (pc_last ? S_IDLE : S_RX_GAP);
            S_RX_GAP:    if (tmr_exp) nxt = S_RX_CHECK;
            S_CLK_OFF:   nxt = S_OFF_WAIT;
            S_OFF_WAIT:  if (tmr_exp) nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // Timer reload value chosen by the wait state being entered.
    always_comb begin
        tmr_load = (nxt != state_q);
        case (nxt)
            S_TX_SETTLE: tmr_val = TW'(TX_SETTLE_CYC - 1);
            S_TX_GAP:    tmr_val = TW'(TX_GAP_CYC - 1);
            S_CLK_WAIT:  tmr_val = TW'(CLK_SETTLE_CYC - 1);
            S_PG_WAIT:   tmr_val = TW'(PG_SETTLE_CYC - 1);
            S_RX_SETTLE: tmr_val = TW'(RX_SETTLE_CYC - 1);
            S_RX_GAP:    tmr_val = TW'(RX_GAP_CYC - 1);
            S_OFF_WAIT:  tmr_val = TW'(OFF_SETTLE_CYC - 1);
            default:     tmr_val = '0;
        endcase
    end

    // Poll counter control: clear on loop entry, step on every check.
    assign pc_clear = tmr_load && ((nxt == S_TX_SETTLE) || (nxt == S_RX_SETTLE));
    assign pc_step  = (state_q == S_TX_CHECK) || (state_q == S_RX_CHECK);
    assign pc_limit = (state_q == S_RX_CHECK) ? PW'(RX_POLLS) : PW'(TX_POLLS);

    cal_delay_timer #(.W(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .value_i   (tmr_val),
        .expired_o (tmr_exp)
    );

    cal_poll_counter #(.W(PW)) u_polls (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pc_clear),
        .step_i  (pc_step),
        .limit_i (pc_limit),
        .last_o  (pc_last)
    );

    // State register and registered control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= S_IDLE;
            tx_cal_req_o   <= 1'b0;
            done_o         <= 1'b0;
            p_4r_o         <= '0;
            n_4r_o         <= '0;
            lane_invalid_o <= '1;
            clk_ref_sel_o  <= 1'b0;
            clk_ovr_o      <= 1'b0;
            pll_pgood_o    <= 1'b0;
            rx_start_o     <= 1'b0;
            tx_err_o       <= 1'b0;
            tx_tmo_o       <= 1'b0;
            rx_tmo_o       <= 1'b0;
        end else begin
            state_q      <= nxt;
            tx_cal_req_o <= 1'b0;
            done_o       <= 1'b0;
            case (state_q)
                S_IDLE: if (start_i) begin
                    tx_cal_req_o <= 1'b1;
                    tx_err_o     <= 1'b0;
                    tx_tmo_o     <= 1'b0;
                    rx_tmo_o     <= 1'b0;
                end
                S_TX_CHECK: if (tx_end) begin
                    tx_err_o       <= tx_cal_err_i;
                    tx_tmo_o       <= ~(tx_cal_done_i | tx_cal_err_i);
                    lane_invalid_o <= '0;
                    if (tx_cal_done_i) begin
                        p_4r_o <= tx_p_res_i >> 1;
                        n_4r_o <= tx_n_res_i >> 1;
                    end else begin
                        p_4r_o <= RES_W'(DEF_4R);
                        n_4r_o <= RES_W'(DEF_4R);
                    end
                end
                S_CLK_ON: begin
                    clk_ref_sel_o <= 1'b1;
                    clk_ovr_o     <= 1'b1;
                end
                S_CLK_WAIT: if (tmr_exp) pll_pgood_o <= 1'b1;
                S_RX_GO:    rx_start_o <= 1'b1;
                S_RX_CHECK: begin
                    if (rx_cal_done_i) begin
                        rx_start_o <= 1'b0;
                    end else if (pc_last) begin
                        rx_tmo_o <= 1'b1;
                        done_o   <= 1'b1;
                    end
                end
                S_CLK_OFF: begin
                    clk_ref_sel_o <= 1'b0;
                    clk_ovr_o     <= 1'b0;
                    pll_pgood_o   <= 1'b0;
                end
                S_OFF_WAIT: if (tmr_exp) begin
                    lane_invalid_o <= '1;
                    done_o         <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o        = (state_q != S_IDLE);
    assign rx_done_clr_o = (state_q == S_RX_GO);

    // Request is a single-cycle pulse.
    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cal_req_o |=> !tx_cal_req_o);

    // Busy only begins in response to a start request.
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // Power-good only while the clock handover is in place.
    assert_pgood_needs_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pll_pgood_o |-> (clk_ref_sel_o && clk_ovr_o));

    // Receive run is preceded by a clear of its done flag.
    assert_clr_before_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_start_o) |-> $past(rx_done_clr_o));

    // While the receive engine runs, every lane is enabled.
    assert_lanes_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start_o |-> (lane_invalid_o == '0));

    // Completion pulse lasts one cycle and coincides with idle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o ##1 !done_o));

    // A clean finish leaves lanes flagged and the clock released.
    assert_clean_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !rx_tmo_o) |-> ((&lane_invalid_o) && !clk_ref_sel_o && !rx_start_o));

    // A receive timeout skips the teardown.
    assert_tmo_no_teardown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && rx_tmo_o) |-> (rx_start_o && pll_pgood_o));

    // Sticky flags are cleared when a new sequence is accepted.
    assert_flags_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!tx_err_o && !tx_tmo_o && !rx_tmo_o));
endmodule

// File: tb/link_cal_seq_tb.sv
module link_cal_seq_tb;
    localparam int TXS = 20, TXG = 5, TXN = 4, CKS = 8, PGS = 3;
    localparam int RXS = 15, RXG = 6, RXN = 3, OFS = 7;
    localparam int LN = 24, RW = 9;
    localparam int SW = 9 + LN + 2 * RW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, start;
    logic busy, done, tx_req, tx_done, tx_err_in;
    logic [RW-1:0] p_res, n_res, p4, n4;
    logic [LN-1:0] lanes;
    logic ref_sel, ovr, pgood, rx_clr, rx_start, rx_done;
    logic te, tt, rt;

    link_cal_seq #(
        .TX_SETTLE_CYC(TXS), .TX_GAP_CYC(TXG), .TX_POLLS(TXN),
        .CLK_SETTLE_CYC(CKS), .PG_SETTLE_CYC(PGS),
        .RX_SETTLE_CYC(RXS), .RX_GAP_CYC(RXG), .RX_POLLS(RXN),
        .OFF_SETTLE_CYC(OFS), .LANES(LN), .RES_W(RW), .DEF_4R(100)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
        .tx_cal_req_o(tx_req), .tx_cal_done_i(tx_done), .tx_cal_err_i(tx_err_in),
        .tx_p_res_i(p_res), .tx_n_res_i(n_res), .p_4r_o(p4), .n_4r_o(n4),
        .lane_invalid_o(lanes), .clk_ref_sel_o(ref_sel), .clk_ovr_o(ovr),
        .pll_pgood_o(pgood), .rx_done_clr_o(rx_clr), .rx_start_o(rx_start),
        .rx_cal_done_i(rx_done), .tx_err_o(te), .tx_tmo_o(tt), .rx_tmo_o(rt)
    );

    // ---------------- engine models ----------------
    int tx_mode;   // 0 never, 1 done, 2 error
    int tx_lat, rx_lat;  // rx_lat < 0: never
    int tx_cnt, rx_cnt;
    bit tx_arm, rx_arm, rs_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b0; tx_err_in <= 1'b0; tx_arm <= 1'b0; tx_cnt <= 0;
        end else if (tx_req) begin
            tx_done <= 1'b0; tx_err_in <= 1'b0; tx_arm <= (tx_mode != 0); tx_cnt <= tx_lat;
        end else if (tx_arm) begin
            if (tx_cnt == 0) begin
                tx_arm <= 1'b0;
                if (tx_mode == 1) tx_done <= 1'b1; else tx_err_in <= 1'b1;
            end else tx_cnt <= tx_cnt - 1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            rx_done <= 1'b0; rx_arm <= 1'b0; rx_cnt <= 0; rs_d <= 1'b0;
        end else begin
            rs_d <= rx_start;
            if (rx_clr) rx_done <= 1'b0;
            if (rx_start && !rs_d && rx_lat >= 0) begin
                rx_arm <= 1'b1; rx_cnt <= rx_lat;
            end else if (rx_arm) begin
                if (rx_cnt == 0) begin rx_arm <= 1'b0; rx_done <= 1'b1; end
                else rx_cnt <= rx_cnt - 1;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int            dly;
        string         req;
        logic [SW-1:0] snap;
    } item_t;
    item_t sbq[$];

    int checks = 0, fails = 0, cyc = 0, last_cyc = 0, req_cnt = 0;
    bit sb_on = 0, clr_d = 0, rsm_d = 0;
    logic [SW-1:0] prev;
    wire [SW-1:0] cur = {done, busy, rx_start, ref_sel, ovr, pgood, te, tt, rt, lanes, p4, n4};

    function automatic logic [SW-1:0] mk(input bit dn, bz, rs, rf, ov, pg, e1, e2, e3,
                                         input logic [LN-1:0] ln,
                                         input logic [RW-1:0] p, n);
        return {dn, bz, rs, rf, ov, pg, e1, e2, e3, ln, p, n};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int d, input string r, input logic [SW-1:0] s);
        item_t it;
        it.dly = d; it.req = r; it.snap = s;
        sbq.push_back(it);
    endtask

    // Monitor: pop one expected item per change of the output bundle.
    always @(negedge clk) begin
        cyc++;
        if (tx_req) req_cnt++;
        if (sb_on && rx_start && !rsm_d)
            chk(clr_d, "R6", "clear pulse before run", 64'(clr_d), 64'd1);
        if (sb_on && cur !== prev) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R2", "unexpected output change", 64'(cur), 64'(prev));
            end else begin
                item_t it;
                it = sbq.pop_front();
                chk(cur === it.snap, it.req, "output bundle", 64'(cur), 64'(it.snap));
                if (it.dly >= 0)
                    chk((cyc - last_cyc) == it.dly, it.req, "cycles since last change",
                        64'(cyc - last_cyc), 64'(it.dly));
            end
            last_cyc = cyc;
        end
        prev  = cur;
        clr_d = rx_clr;
        rsm_d = rx_start;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Driver: push the expected sequence, then launch it.
    task automatic run_seq(input int mode, input int tlat, input int rlat,
                           input logic [RW-1:0] pr, nr,
                           input logic [RW-1:0] pold, nold, pexp, nexp,
                           input int txd, input bit xe, xt, input string ttag,
                           input int rxd, input bit xrt, input bit poke);
        int want;
        tx_mode = mode; tx_lat = tlat; rx_lat = rlat; p_res = pr; n_res = nr;
        push(-1, "R10", mk(0,1,0,0,0,0,0,0,0,'1,pold,nold));
        push(txd, ttag, mk(0,1,0,0,0,0,xe,xt,0,'0,pexp,nexp));
        push(1, "R6", mk(0,1,0,1,1,0,xe,xt,0,'0,pexp,nexp));
        push(CKS, "R6", mk(0,1,0,1,1,1,xe,xt,0,'0,pexp,nexp));
        push(PGS + 1, "R6", mk(0,1,1,1,1,1,xe,xt,0,'0,pexp,nexp));
        if (xrt) begin
            push(rxd, "R9", mk(1,0,1,1,1,1,xe,xt,1,'0,pexp,nexp));
            push(1, "R9", mk(0,0,1,1,1,1,xe,xt,1,'0,pexp,nexp));
        end else begin
            push(rxd, "R7", mk(0,1,0,1,1,1,xe,xt,0,'0,pexp,nexp));
            push(1, "R8", mk(0,1,0,0,0,0,xe,xt,0,'0,pexp,nexp));
            push(OFS, "R8", mk(1,0,0,0,0,0,xe,xt,0,'1,pexp,nexp));
            push(1, "R8", mk(0,0,0,0,0,0,xe,xt,0,'1,pexp,nexp));
        end
        want = req_cnt + 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin   // R2: start while busy must be ignored
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(req_cnt == want, "R2", "request pulses", 64'(req_cnt), 64'(want));
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0;
        tx_mode = 1; tx_lat = 5; rx_lat = 4; p_res = '0; n_res = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cur === mk(0,0,0,0,0,0,0,0,0,'1,'0,'0), "R1", "reset bundle", 64'(cur), 64'(mk(0,0,0,0,0,0,0,0,0,'1,'0,'0)));
        chk(!tx_req && !rx_clr, "R1", "reset pulses", 64'({tx_req, rx_clr}), 64'd0);
        prev = cur; last_cyc = cyc; sb_on = 1;

        // R3 R5 R7 R8: clean run, halved results, early checks; start ignored while busy
        run_seq(1, 5, 4, 9'h1A5, 9'h0C8, 9'd0, 9'd0, 9'd210, 9'd100,
                TXS + 1, 0, 0, "R5", RXS + 1, 0, 1);
        // R3 R5 R7: transmit error on 3rd check -> defaults; receive done on last allowed check
        run_seq(2, 27, 25, 9'h1A5, 9'h0C8, 9'd210, 9'd100, 9'd100, 9'd100,
                TXS + 1 + 2 * (TXG + 1), 1, 0, "R3", RXS + 1 + 2 * (RXG + 1), 0, 0);
        // R4 R10: transmit timeout, previous error flag cleared at start
        run_seq(0, 0, 4, 9'h1A5, 9'h0C8, 9'd100, 9'd100, 9'd100, 9'd100,
                TXS + 1 + (TXN - 1) * (TXG + 1), 0, 1, "R4", RXS + 1, 0, 0);
        // R9 R10: receive timeout, no teardown; transmit timeout flag cleared
        run_seq(1, 5, -1, 9'h1FF, 9'h081, 9'd100, 9'd100, 9'd255, 9'd64,
                TXS + 1, 0, 0, "R5", RXS + 1 + (RXN - 1) * (RXG + 1), 1, 0);
        chk(rt === 1'b1 && !busy, "R10", "sticky receive timeout", 64'(rt), 64'd1);

        // R1: reset restores idle levels after a timed-out run
        sb_on = 0;
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cur === mk(0,0,0,0,0,0,0,0,0,'1,'0,'0), "R1", "reset after timeout", 64'(cur), 64'(mk(0,0,0,0,0,0,0,0,0,'1,'0,'0)));
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=sequence_end");
        summary();
        $finish;
    end
endmodule